// File: doc/BRIEF.md
# Flag-Aware Microcode Sequencer

This block is the microprogrammed control unit of a small 8-bit processor. Each cycle it forms a lookup index from the opcode held in the instruction register, the two interrupt-control bits, its own 4-bit micro-step count and the four ALU flags (zero, overflow, negative, carry). It then decodes that index combinationally into a 48-bit control word that drives the rest of the datapath. The ALU, register file and memory sit outside this block.

All conditional behaviour is resolved inside the control store, per flag combination. Examples are whether a conditional jump is taken, whether an interrupt is entered, and whether the inhibit instructions act. No separate branch unit exists. The step counter returns to zero whenever the current word carries the step-clear bit. The word is also presented as three 16-bit slices, matching a store built from three 16-bit-wide memories.

Top module: `uc_sequencer`

## Requirements
- R1: The lookup index is 18 bits, most significant first: opcode [17:10], inhibit [9], request [8], step [7:4], zero flag [3], overflow flag [2], negative flag [1], carry flag [0].
- R2: The step counter clears to 0 on a clock edge with rst high. Otherwise it increments by one on each edge, unless the current word has bit 0 (step clear) set, in which case it returns to 0.
- R3: At step 0, every opcode other than 0x00 produces the fetch word: bit 1 (PC drives address), bit 2 (memory drives bus), bit 3 (instruction register load) and bit 4 (PC increment), and no other bits.
- R4: The first step after an instruction's body carries bit 0 alone. Opcodes with no definition (above 0x10) clear at step 1.
- R5: Opcode 0x01 at step 1 gives bits 1, 2, 4 and 5 (A load), then clears at step 2. Opcode 0x02 gives bits 1, 2, 4 and 6 (transfer-low load) at step 1; bits 1, 2, 4 and 7 (transfer-high load) at step 2; bits 2, 5 and 8 (transfer register drives address) at step 3; and clears at step 4.
- R6: Jump opcodes test one flag each. 0x05 jumps if Z is set, 0x06 if Z is clear, 0x07 if O is set, 0x08 if O is clear, 0x09 if N is set, 0x0A if N is clear, 0x0B if C is set and 0x0C if C is clear. A taken jump gives bits 1, 2, 4 and 6 at step 1; bits 1, 2 and 7 at step 2; bits 8 and 9 (PC load) at step 3; and clears at step 4. A jump that is not taken gives bit 4 alone at steps 1 and 2 and clears at step 3.
- R7: Opcode 0x0D is taken only when N and Z are both clear. Otherwise it behaves as a jump that is not taken.
- R8: With request=1 and inhibit=0, every opcode except 0x00 and 0x10 enters the vector sequence at the step where it would otherwise clear. The sequence gives bits 15 (zero source) and 16 (vector register write); then bits 18 (zero drive) and 7; then bits 17 (vector drive) and 6; then bits 8 and 9. The step after that clears.
- R9: Opcode 0x0E gives bit 13 (inhibit set) at step 1 and clears at step 2, but only when inhibit and request are both 0. Otherwise its body is empty. Opcode 0x0F gives bit 14 (inhibit clear) at step 1 when inhibit=1, and clears at step 1 when inhibit=0.
- R10: With inhibit=1, no interrupt entry occurs, whatever the request bit; bit 16 is never asserted.
- R11: slice0 carries word bits 15:0, slice1 carries bits 31:16 and slice2 carries bits 47:32.
- R12: Every path, including an inserted jump and vector sequence, clears by step 15. At step 15, bit 0 is always set.
- R13: Opcode 0x00 has no fetch. It gives bit 15 at step 0; bits 5, 6, 7, 10 (flags write), 18, 19 (B load) and 47 (display clear) at step 1; bits 8 and 32 (stack pointer load) at step 2; bit 33 (stack pointer decrement) at step 3; bits 8 and 9 at step 4; and clears at step 5. Opcode 0x10 gives bit 13 at step 1 and clears at step 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Current instruction register value |
| flag_z | input | 1 | Zero flag |
| flag_o | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| irq_inhibit | input | 1 | Interrupts inhibited |
| irq_request | input | 1 | Interrupt pending |
| lookup_index | output | 18 | Control-store lookup index |
| ctrl_word | output | 48 | Logical control word |
| ctrl_slice0 | output | 16 | Control word bits 15:0 |
| ctrl_slice1 | output | 16 | Control word bits 31:16 |
| ctrl_slice2 | output | 16 | Control word bits 47:32 |

## Verification
A flag-dependent jump and interrupt entry can fall in the same cycle. In that case the vector sequence must start exactly at the end of the taken or untaken jump body. The bench provokes this with opcode 0x05, zero flag set, request high and inhibit low. It expects the full taken-jump steps 1 to 3, the vector write at step 4, and the clear at step 8. The set-inhibit opcode with a pending request is also driven. There the vector entry must replace the inhibit-set action at step 1.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int OP_W     = 8;
    localparam int STEP_W   = 4;
    localparam int N_STEPS  = 1 << STEP_W;
    localparam int SLICE_W  = 16;
    localparam int N_SLICES = 3;
    localparam int CW_W     = SLICE_W * N_SLICES;
    localparam int IDX_W    = OP_W + 2 + STEP_W + 4;
    localparam int LEN_W    = STEP_W + 1;
    localparam int VEC_LEN  = 5;

    typedef logic [CW_W-1:0] cword_t;

    // control bit positions
    localparam int B_STEP_CLR = 0;
    localparam int B_PC_OUT   = 1;
    localparam int B_MEM_OUT  = 2;
    localparam int B_IR_LD    = 3;
    localparam int B_PC_INC   = 4;
    localparam int B_A_LD     = 5;
    localparam int B_TRL_LD   = 6;
    localparam int B_TRH_LD   = 7;
    localparam int B_TR_OUT   = 8;
    localparam int B_PC_LD    = 9;
    localparam int B_FLG_WR   = 10;
    localparam int B_INH_SET  = 13;
    localparam int B_INH_CLR  = 14;
    localparam int B_ZERO_GEN = 15;
    localparam int B_VEC_WR   = 16;
    localparam int B_VEC_OUT  = 17;
    localparam int B_ZERO_OUT = 18;
    localparam int B_B_LD     = 19;
    localparam int B_SP_LD    = 32;
    localparam int B_SP_DEC   = 33;
    localparam int B_DISP_CLR = 47;
    localparam int B_CARRY_S  = 11;
    localparam int B_CARRY_C  = 12;

    localparam cword_t W_CLR   = cword_t'(1) << B_STEP_CLR;
    localparam cword_t W_FETCH = (cword_t'(1) << B_PC_OUT) | (cword_t'(1) << B_MEM_OUT)
                               | (cword_t'(1) << B_IR_LD)  | (cword_t'(1) << B_PC_INC);

    // opcode assignments
    localparam logic [OP_W-1:0] OP_RESET  = 8'h00;
    localparam logic [OP_W-1:0] OP_LDI    = 8'h01;
    localparam logic [OP_W-1:0] OP_LDA    = 8'h02;
    localparam logic [OP_W-1:0] OP_SEC    = 8'h03;
    localparam logic [OP_W-1:0] OP_CLC    = 8'h04;
    localparam logic [OP_W-1:0] OP_JZ     = 8'h05;
    localparam logic [OP_W-1:0] OP_JNZ    = 8'h06;
    localparam logic [OP_W-1:0] OP_JO     = 8'h07;
    localparam logic [OP_W-1:0] OP_JNO    = 8'h08;
    localparam logic [OP_W-1:0] OP_JN     = 8'h09;
    localparam logic [OP_W-1:0] OP_JP     = 8'h0A;
    localparam logic [OP_W-1:0] OP_JC     = 8'h0B;
    localparam logic [OP_W-1:0] OP_JNC    = 8'h0C;
    localparam logic [OP_W-1:0] OP_JGZ    = 8'h0D;
    localparam logic [OP_W-1:0] OP_SETINH = 8'h0E;
    localparam logic [OP_W-1:0] OP_CLRINH = 8'h0F;
    localparam logic [OP_W-1:0] OP_ISR    = 8'h10;

    typedef struct packed {
        logic inh;
        logic req;
        logic z;
        logic o;
        logic n;
        logic c;
    } cond_t;

    typedef struct packed {
        logic [LEN_W-1:0]          len;
        cword_t [N_STEPS-1:0]      w;
    } prog_t;

    function automatic cword_t bit_w(input int b);
        return cword_t'(1) << b;
    endfunction

    function automatic logic is_jump(input logic [OP_W-1:0] op);
        return (op >= OP_JZ) && (op <= OP_JGZ);
    endfunction

    function automatic logic jump_taken(input logic [OP_W-1:0] op, input cond_t f);
        logic t;
        case (op)
            OP_JZ:   t = f.z;
            OP_JNZ:  t = !f.z;
            OP_JO:   t = f.o;
            OP_JNO:  t = !f.o;
            OP_JN:   t = f.n;
            OP_JP:   t = !f.n;
            OP_JC:   t = f.c;
            OP_JNC:  t = !f.c;
            OP_JGZ:  t = !f.n && !f.z;
            default: t = 1'b0;
        endcase
        return t;
    endfunction

    // body of one opcode before interrupt insertion
    function automatic prog_t base_prog(input logic [OP_W-1:0] op, input cond_t f);
        prog_t p;
        p      = '0;
        p.w[0] = W_FETCH;
        p.len  = LEN_W'(1);
        if (op == OP_RESET) begin
            p.w[0] = bit_w(B_ZERO_GEN);
            p.w[1] = bit_w(B_ZERO_OUT) | bit_w(B_A_LD) | bit_w(B_B_LD) | bit_w(B_TRL_LD)
                   | bit_w(B_TRH_LD) | bit_w(B_FLG_WR) | bit_w(B_DISP_CLR);
            p.w[2] = bit_w(B_TR_OUT) | bit_w(B_SP_LD);
            p.w[3] = bit_w(B_SP_DEC);
            p.w[4] = bit_w(B_TR_OUT) | bit_w(B_PC_LD);
            p.len  = LEN_W'(5);
        end else if (op == OP_LDI) begin
            p.w[1] = bit_w(B_PC_OUT) | bit_w(B_MEM_OUT) | bit_w(B_A_LD) | bit_w(B_PC_INC);
            p.len  = LEN_W'(2);
        end else if (op == OP_LDA) begin
            p.w[1] = bit_w(B_PC_OUT) | bit_w(B_MEM_OUT) | bit_w(B_TRL_LD) | bit_w(B_PC_INC);
            p.w[2] = bit_w(B_PC_OUT) | bit_w(B_MEM_OUT) | bit_w(B_TRH_LD) | bit_w(B_PC_INC);
            p.w[3] = bit_w(B_TR_OUT) | bit_w(B_MEM_OUT) | bit_w(B_A_LD);
            p.len  = LEN_W'(4);
        end else if (op == OP_SEC) begin
            p.w[1] = bit_w(B_CARRY_S) | bit_w(B_FLG_WR);
            p.len  = LEN_W'(2);
        end else if (op == OP_CLC) begin
            p.w[1] = bit_w(B_CARRY_C) | bit_w(B_FLG_WR);
            p.len  = LEN_W'(2);
        end else if (is_jump(op)) begin
            if (jump_taken(op, f)) begin
                p.w[1] = bit_w(B_PC_OUT) | bit_w(B_MEM_OUT) | bit_w(B_TRL_LD) | bit_w(B_PC_INC);
                p.w[2] = bit_w(B_PC_OUT) | bit_w(B_MEM_OUT) | bit_w(B_TRH_LD);
                p.w[3] = bit_w(B_TR_OUT) | bit_w(B_PC_LD);
                p.len  = LEN_W'(4);
            end else begin
                p.w[1] = bit_w(B_PC_INC);
                p.w[2] = bit_w(B_PC_INC);
                p.len  = LEN_W'(3);
            end
        end else if (op == OP_SETINH) begin
            if (!f.inh && !f.req) begin
                p.w[1] = bit_w(B_INH_SET);
                p.len  = LEN_W'(2);
            end
        end else if (op == OP_CLRINH) begin
            if (f.inh) begin
                p.w[1] = bit_w(B_INH_CLR);
                p.len  = LEN_W'(2);
            end
        end else if (op == OP_ISR) begin
            p.w[1] = bit_w(B_INH_SET);
            p.len  = LEN_W'(2);
        end
        return p;
    endfunction

    // k-th step of the interrupt redirection
    function automatic cword_t vec_step(input logic [LEN_W-1:0] k);
        cword_t w;
        case (k)
            LEN_W'(0): w = bit_w(B_ZERO_GEN) | bit_w(B_VEC_WR);
            LEN_W'(1): w = bit_w(B_ZERO_OUT) | bit_w(B_TRH_LD);
            LEN_W'(2): w = bit_w(B_VEC_OUT)  | bit_w(B_TRL_LD);
            LEN_W'(3): w = bit_w(B_TR_OUT)   | bit_w(B_PC_LD);
            default:   w = W_CLR;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/uc_step_ctr.sv
module uc_step_ctr #(
    parameter int STEP_W = uc_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_clr,
    output logic [STEP_W-1:0] step
);
    typedef struct packed {
        logic [STEP_W-1:0] step;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_clr) st_d.step = '0;
        else          st_d.step = st_q.step + STEP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step = st_q.step;
endmodule

// File: rtl/uc_index_form.sv
module uc_index_form #(
    parameter int OP_W   = uc_pkg::OP_W,
    parameter int STEP_W = uc_pkg::STEP_W,
    localparam int IDX_W = OP_W + 2 + STEP_W + 4
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic              inh,
    input  logic              req,
    input  logic [STEP_W-1:0] step,
    input  logic              z,
    input  logic              o,
    input  logic              n,
    input  logic              c,
    output logic [IDX_W-1:0]  index
);
    always_comb begin
        index = {opcode, inh, req, step, z, o, n, c};
    end
endmodule

// File: rtl/uc_ctrl_store.sv
module uc_ctrl_store
    import uc_pkg::*;
(
    input  logic [IDX_W-1:0] index,
    output cword_t           word
);
    logic [OP_W-1:0]   op;
    logic [STEP_W-1:0] step;
    cond_t             f;
    prog_t             prog;
    logic              int_en;
    logic [LEN_W-1:0]  st_ext;
    logic [LEN_W-1:0]  past_end;

    always_comb begin
        op     = index[IDX_W-1 -: OP_W];
        f.inh  = index[STEP_W+5];
        f.req  = index[STEP_W+4];
        step   = index[STEP_W+3:4];
        f.z    = index[3];
        f.o    = index[2];
        f.n    = index[1];
        f.c    = index[0];

        prog     = base_prog(op, f);
        int_en   = f.req && !f.inh && (op != OP_RESET) && (op != OP_ISR);
        st_ext   = {1'b0, step};
        past_end = st_ext - prog.len;

        if (st_ext < prog.len)
            word = prog.w[step];
        else if (int_en && (past_end < LEN_W'(VEC_LEN)))
            word = vec_step(past_end);
        else
            word = W_CLR;
    end
endmodule

// File: rtl/uc_word_split.sv
module uc_word_split #(
    parameter int SLICE_W  = uc_pkg::SLICE_W,
    parameter int N_SLICES = uc_pkg::N_SLICES,
    localparam int WORD_W  = SLICE_W * N_SLICES
) (
    input  logic [WORD_W-1:0]                word,
    output logic [N_SLICES-1:0][SLICE_W-1:0] slices
);
    for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
        assign slices[g] = word[g*SLICE_W +: SLICE_W];
    end
endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     opcode,
    input  logic                flag_z,
    input  logic                flag_o,
    input  logic                flag_n,
    input  logic                flag_c,
    input  logic                irq_inhibit,
    input  logic                irq_request,
    output logic [IDX_W-1:0]    lookup_index,
    output logic [CW_W-1:0]     ctrl_word,
    output logic [SLICE_W-1:0]  ctrl_slice0,
    output logic [SLICE_W-1:0]  ctrl_slice1,
    output logic [SLICE_W-1:0]  ctrl_slice2
);
    logic [STEP_W-1:0]                step;
    cword_t                           word;
    logic [N_SLICES-1:0][SLICE_W-1:0] slices;

    uc_step_ctr #(.STEP_W(STEP_W)) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .step_clr (word[B_STEP_CLR]),
        .step     (step)
    );

    uc_index_form #(.OP_W(OP_W), .STEP_W(STEP_W)) idx_i (
        .opcode (opcode),
        .inh    (irq_inhibit),
        .req    (irq_request),
        .step   (step),
        .z      (flag_z),
        .o      (flag_o),
        .n      (flag_n),
        .c      (flag_c),
        .index  (lookup_index)
    );

    uc_ctrl_store store_i (
        .index (lookup_index),
        .word  (word)
    );

    uc_word_split #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) split_i (
        .word   (word),
        .slices (slices)
    );

    assign ctrl_word   = word;
    assign ctrl_slice0 = slices[0];
    assign ctrl_slice1 = slices[1];
    assign ctrl_slice2 = slices[2];
endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk
    import uc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OP_W-1:0]     opcode,
    input logic                flag_z,
    input logic                flag_o,
    input logic                flag_n,
    input logic                flag_c,
    input logic                irq_inhibit,
    input logic                irq_request,
    input logic [IDX_W-1:0]    lookup_index,
    input logic [CW_W-1:0]     ctrl_word,
    input logic [SLICE_W-1:0]  ctrl_slice0,
    input logic [SLICE_W-1:0]  ctrl_slice1,
    input logic [SLICE_W-1:0]  ctrl_slice2
);
    logic [STEP_W-1:0] cur_step;
    assign cur_step = lookup_index[STEP_W+3:4];

    assert_reset_step_R2: assert property (@(posedge clk)
        rst |=> cur_step == '0);

    assert_clear_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[B_STEP_CLR] |=> cur_step == '0);

    assert_advance_step_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[B_STEP_CLR] |=> cur_step == STEP_W'($past(cur_step) + STEP_W'(1)));

    assert_fetch_word_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_step == '0 && opcode != OP_RESET) |-> ctrl_word == W_FETCH);

    assert_no_vector_inhibited_R10: assert property (@(posedge clk) disable iff (rst)
        irq_inhibit |-> !ctrl_word[B_VEC_WR]);

    assert_fits_steps_R12: assert property (@(posedge clk) disable iff (rst)
        (cur_step == STEP_W'(N_STEPS - 1)) |-> ctrl_word[B_STEP_CLR]);

    always_comb begin
        if (!rst) begin
            assert_slices_R11: assert ({ctrl_slice2, ctrl_slice1, ctrl_slice0} == ctrl_word);
        end
    end
endmodule

bind uc_sequencer uc_sequencer_chk chk_i (.*);

// File: tb/uc_sequencer_tb_top.sv
module uc_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = 8'h00;
    logic        flag_z = 1'b0, flag_o = 1'b0, flag_n = 1'b0, flag_c = 1'b0;
    logic        irq_inhibit = 1'b0, irq_request = 1'b0;
    logic [17:0] lookup_index;
    logic [47:0] ctrl_word;
    logic [15:0] ctrl_slice0, ctrl_slice1, ctrl_slice2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uc_sequencer dut_i (
        .clk          (clk),
        .rst          (rst),
        .opcode       (opcode),
        .flag_z       (flag_z),
        .flag_o       (flag_o),
        .flag_n       (flag_n),
        .flag_c       (flag_c),
        .irq_inhibit  (irq_inhibit),
        .irq_request  (irq_request),
        .lookup_index (lookup_index),
        .ctrl_word    (ctrl_word),
        .ctrl_slice0  (ctrl_slice0),
        .ctrl_slice1  (ctrl_slice1),
        .ctrl_slice2  (ctrl_slice2)
    );

    localparam logic [47:0] M_CLR  = 48'h1 << 0;
    localparam logic [47:0] M_PCO  = 48'h1 << 1;
    localparam logic [47:0] M_MEMO = 48'h1 << 2;
    localparam logic [47:0] M_IRL  = 48'h1 << 3;
    localparam logic [47:0] M_PCI  = 48'h1 << 4;
    localparam logic [47:0] M_AL   = 48'h1 << 5;
    localparam logic [47:0] M_TRL  = 48'h1 << 6;
    localparam logic [47:0] M_TRH  = 48'h1 << 7;
    localparam logic [47:0] M_TRO  = 48'h1 << 8;
    localparam logic [47:0] M_PCL  = 48'h1 << 9;
    localparam logic [47:0] M_FW   = 48'h1 << 10;
    localparam logic [47:0] M_CS   = 48'h1 << 11;
    localparam logic [47:0] M_CC   = 48'h1 << 12;
    localparam logic [47:0] M_ISET = 48'h1 << 13;
    localparam logic [47:0] M_ICLR = 48'h1 << 14;
    localparam logic [47:0] M_ZG   = 48'h1 << 15;
    localparam logic [47:0] M_VW   = 48'h1 << 16;
    localparam logic [47:0] M_VO   = 48'h1 << 17;
    localparam logic [47:0] M_ZO   = 48'h1 << 18;
    localparam logic [47:0] M_BL   = 48'h1 << 19;
    localparam logic [47:0] M_SPL  = 48'h1 << 32;
    localparam logic [47:0] M_SPD  = 48'h1 << 33;
    localparam logic [47:0] M_DCLR = 48'h1 << 47;

    localparam logic [47:0] M_FETCH = M_PCO | M_MEMO | M_IRL | M_PCI;
    localparam logic [47:0] M_JT1   = M_PCO | M_MEMO | M_TRL | M_PCI;
    localparam logic [47:0] M_JT2   = M_PCO | M_MEMO | M_TRH;
    localparam logic [47:0] M_JT3   = M_TRO | M_PCL;

    // flags field order: {inhibit, request, Z, O, N, C}
    typedef struct packed {
        logic [23:0] tag;
        logic [7:0]  op;
        logic [5:0]  fl;
        logic [3:0]  st;
        logic [47:0] exp;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t VECS [NV] = '{
        '{"R3",  8'h01, 6'b000000, 4'd0, M_FETCH},
        '{"R5",  8'h01, 6'b000000, 4'd1, M_PCO | M_MEMO | M_AL | M_PCI},
        '{"R4",  8'h01, 6'b000000, 4'd2, M_CLR},
        '{"R5",  8'h02, 6'b000000, 4'd1, M_JT1},
        '{"R5",  8'h02, 6'b000000, 4'd2, M_PCO | M_MEMO | M_TRH | M_PCI},
        '{"R5",  8'h02, 6'b000000, 4'd3, M_TRO | M_MEMO | M_AL},
        '{"R4",  8'h02, 6'b000000, 4'd4, M_CLR},
        '{"R4",  8'h03, 6'b000000, 4'd1, M_CS | M_FW},
        '{"R4",  8'h04, 6'b000000, 4'd1, M_CC | M_FW},
        '{"R6",  8'h05, 6'b001000, 4'd1, M_JT1},
        '{"R6",  8'h05, 6'b001000, 4'd2, M_JT2},
        '{"R6",  8'h05, 6'b001000, 4'd3, M_JT3},
        '{"R6",  8'h05, 6'b001000, 4'd4, M_CLR},
        '{"R6",  8'h05, 6'b000000, 4'd1, M_PCI},
        '{"R6",  8'h05, 6'b000000, 4'd2, M_PCI},
        '{"R6",  8'h05, 6'b000000, 4'd3, M_CLR},
        '{"R6",  8'h06, 6'b000000, 4'd1, M_JT1},
        '{"R6",  8'h06, 6'b001000, 4'd1, M_PCI},
        '{"R6",  8'h07, 6'b000100, 4'd2, M_JT2},
        '{"R6",  8'h08, 6'b000100, 4'd1, M_PCI},
        '{"R6",  8'h09, 6'b000010, 4'd1, M_JT1},
        '{"R6",  8'h0A, 6'b000000, 4'd1, M_JT1},
        '{"R6",  8'h0A, 6'b000010, 4'd1, M_PCI},
        '{"R6",  8'h0B, 6'b000001, 4'd3, M_JT3},
        '{"R6",  8'h0C, 6'b000001, 4'd1, M_PCI},
        '{"R7",  8'h0D, 6'b000000, 4'd1, M_JT1},
        '{"R7",  8'h0D, 6'b001000, 4'd1, M_PCI},
        '{"R7",  8'h0D, 6'b000010, 4'd1, M_PCI},
        '{"R7",  8'h0D, 6'b000101, 4'd3, M_JT3},
        '{"R9",  8'h0E, 6'b000000, 4'd1, M_ISET},
        '{"R9",  8'h0E, 6'b100000, 4'd1, M_CLR},
        '{"R9",  8'h0F, 6'b100000, 4'd1, M_ICLR},
        '{"R9",  8'h0F, 6'b000000, 4'd1, M_CLR},
        '{"R8",  8'h01, 6'b010000, 4'd2, M_ZG | M_VW},
        '{"R8",  8'h01, 6'b010000, 4'd3, M_ZO | M_TRH},
        '{"R8",  8'h01, 6'b010000, 4'd4, M_VO | M_TRL},
        '{"R8",  8'h01, 6'b010000, 4'd5, M_JT3},
        '{"R8",  8'h01, 6'b010000, 4'd6, M_CLR},
        '{"R8",  8'h00, 6'b010000, 4'd5, M_CLR},
        '{"R8",  8'h10, 6'b010000, 4'd2, M_CLR},
        '{"R10", 8'h01, 6'b110000, 4'd2, M_CLR},
        '{"R9",  8'h0F, 6'b110000, 4'd1, M_ICLR},
        '{"R4",  8'h55, 6'b000000, 4'd1, M_CLR},
        '{"R8",  8'h55, 6'b010000, 4'd1, M_ZG | M_VW},
        '{"R12", 8'h05, 6'b011000, 4'd4, M_ZG | M_VW},
        '{"R12", 8'h05, 6'b011000, 4'd8, M_CLR},
        '{"R13", 8'h00, 6'b000000, 4'd1, M_ZO | M_AL | M_BL | M_TRL | M_TRH | M_FW | M_DCLR},
        '{"R8",  8'h0E, 6'b010000, 4'd1, M_ZG | M_VW}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply inputs, reset, then advance st steps; returns just after an edge
    task automatic run_to(input logic [7:0] op, input logic [5:0] fl, input int st);
        opcode = op;
        {irq_inhibit, irq_request, flag_z, flag_o, flag_n, flag_c} = fl;
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        repeat (st) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // reset state: step 0, fetch word (R2, R3)
        run_to(8'h01, 6'b000000, 0);
        chk("R2 reset step", 64'(lookup_index[7:4]), 64'd0);
        chk("R3 reset fetch", 64'(ctrl_word), 64'(M_FETCH));

        // table walk (R1 index, R11 slices, word per entry)
        for (int i = 0; i < NV; i++) begin
            run_to(VECS[i].op, VECS[i].fl, int'(VECS[i].st));
            chk($sformatf("%s word op=%h st=%0d", VECS[i].tag, VECS[i].op, VECS[i].st),
                64'(ctrl_word), 64'(VECS[i].exp));
            chk("R1 index", 64'(lookup_index),
                64'({VECS[i].op, VECS[i].fl[5], VECS[i].fl[4], VECS[i].st, VECS[i].fl[3:0]}));
            chk("R11 slices", 64'({ctrl_slice2, ctrl_slice1, ctrl_slice0}), 64'(VECS[i].exp));
        end

        // reset sequence start, no fetch (R13)
        run_to(8'h00, 6'b000000, 0);
        chk("R13 step0", 64'(ctrl_word), 64'(M_ZG));
        @(posedge clk); @(posedge clk); #1;
        chk("R13 step2", 64'(ctrl_word), 64'(M_TRO | M_SPL));
        chk("R11 slice2 step2", 64'(ctrl_slice2), 64'h1);
        @(posedge clk); #1;
        chk("R13 step3", 64'(ctrl_word), 64'(M_SPD));
        @(posedge clk); @(posedge clk); #1;
        chk("R13 step5", 64'(ctrl_word), 64'(M_CLR));
        run_to(8'h10, 6'b000000, 1);
        chk("R13 handler step1", 64'(ctrl_word), 64'(M_ISET));

        // counter returns to 0 after clear (R2)
        run_to(8'h01, 6'b000000, 2);
        @(posedge clk); #1;
        chk("R2 after clear", 64'(lookup_index[7:4]), 64'd0);
        chk("R3 refetch", 64'(ctrl_word), 64'(M_FETCH));

        // undefined opcode cannot hang (R4)
        run_to(8'hC3, 6'b001111, 1);
        chk("R4 undefined clear", 64'(ctrl_word), 64'(M_CLR));
        @(posedge clk); #1;
        chk("R4 undefined back to 0", 64'(lookup_index[7:4]), 64'd0);

        // interrupt path ends and wraps (R8)
        run_to(8'h01, 6'b010000, 6);
        @(posedge clk); #1;
        chk("R8 vector then step 0", 64'(lookup_index[7:4]), 64'd0);

        // inhibit blocks entry even on longest body (R10)
        run_to(8'h02, 6'b110000, 4);
        chk("R10 no vector", 64'(ctrl_word), 64'(M_CLR));

        // reset mid-instruction (R2)
        run_to(8'h02, 6'b000000, 3);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk("R2 mid reset", 64'(lookup_index[7:4]), 64'd0);

        finish_run();
    end

endmodule